// File: doc/BRIEF.md
# External Bus Strobe Timing Sequencer

The sequencer carries out one asynchronous external memory access at a time. Each access has three timed phases: a lead phase, an active phase and a trail phase. Phase lengths are counted in cycles of an internal timing clock, which is the system clock divided by one or two. The block also produces an external bus clock. That clock runs at the timing rate or at half of it, and it can be switched off and held low. The block drives a chip-select, a read/write direction line, a read strobe and two byte write strobes.

An access is requested on a valid/ready port that carries the address, the write data, the direction and the byte enables. The requester holds `req_valid` and the request fields steady until `req_ready` is seen high. `req_ready` is high for exactly one system clock, when the access has finished. Read data is valid on `rsp_rdata` in that same cycle. Back-pressure is the whole access time, so a requester never sees `req_ready` before the trail phase completes.

An access may only start in phase with a rising edge of the external clock. As a result, strobe edges fall on a rising or a falling external edge depending on whether the count of timing cycles up to that edge is even or odd. In half-rate external mode a sideband pair reports which edge each strobe change used.

Top module: `xbus_strobe_seq`

## Requirements
- R1: After reset, `bus_cs_n`=1, `bus_rd_n`=1, `bus_wr_n`=2'b11, `bus_rnw`=1 (read) and `req_ready`=0.
- R2: Chip-select falls to the first strobe assertion in lead×D system clocks. D=2 when `cfg_tim_half`=1, otherwise D=1. Lead is `cfg_lead`, and a value of 0 counts as 1.
- R3: Strobes stay low for (A+W)×D system clocks. A is `cfg_active`, and a value of 0 counts as 1. W is the number of added wait cycles.
- R4: The strobe release comes `cfg_trail`×D system clocks before chip-select rises. With trail 0, both change in the same cycle.
- R5: `req_ready` is high for exactly one system clock, in the first cycle in which chip-select is high again. For reads, `rsp_rdata` then equals `bus_rdata` as sampled on the final active cycle.
- R6: `bus_ready` is sampled at each timing tick that ends the last programmed active cycle. While it is low, one active cycle is added per tick, up to a limit of 255 added cycles.
- R7: A write drives `bus_wr_n` = ~`req_be` while keeping `bus_rd_n` high, and drives `bus_rnw`=0 for the whole access. A read pulls only `bus_rd_n` low. `bus_rnw` returns to 1 when chip-select rises. `bus_addr` holds the request address while chip-select is low.
- R8: With `cfg_ext_half`=1, an access starts only on a rising external clock edge. `bus_clk` is high in the cycle in which chip-select first reads low.
- R9: With `cfg_ext_half`=1, each chip-select or strobe change comes with `edge_tag_valid`=1. `edge_tag_fall`=1 means a falling external edge was used. The start is always rising. The strobe assertion is falling exactly when the effective lead is odd. The strobe release is falling exactly when lead+A+W is odd. With `cfg_ext_half`=0, `edge_tag_valid` stays 0.
- R10: With `cfg_ext_off`=1, `bus_clk` is held at 0. In half-rate external mode, `bus_clk` changes level once per timing tick. In full-rate external mode with the half-rate timing clock, it changes level every system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tim_half | input | 1 | Timing clock = system clock / 2 |
| cfg_ext_half | input | 1 | External clock = timing clock / 2 |
| cfg_ext_off | input | 1 | Hold external clock low |
| cfg_lead | input | 2 | Lead cycles (0 treated as 1) |
| cfg_active | input | 3 | Active cycles (0 treated as 1) |
| cfg_trail | input | 2 | Trail cycles |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access complete, one-cycle pulse |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Request write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables for writes |
| rsp_rdata | output | 16 | Read data, valid with req_ready |
| bus_clk | output | 1 | External bus clock |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 2 | Byte write strobes, active low |
| bus_addr | output | 20 | Address held during the access |
| bus_wdata | output | 16 | Write data held during the access |
| bus_rdata | input | 16 | Read data from the device |
| bus_ready | input | 1 | Device ready; low adds wait cycles |
| edge_tag_valid | output | 1 | A strobe or chip-select changed this cycle |
| edge_tag_fall | output | 1 | That change used a falling external edge |

## Verification
The hardest case to reach is the wait-cycle ceiling. It needs `bus_ready` held low through more than 255 consecutive ready samples. The stimulus therefore asks for 300 wait cycles and expects the strobe to release after exactly 255. The external clock phase at the start of an access is also hard to reach, because it depends on the parity of the previous access. Odd-length accesses in half-rate mode leave the clock misaligned, and the next start must then show a rising edge. The bench places ready changes on timing ticks by counting system clocks from the observed strobe edge.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_ACT   = 2'd2,
    ST_TRAIL = 2'd3
  } xbs_state_t;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/xbs_clkgen.sv
module xbs_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic tim_half,
  input  logic ext_half,
  input  logic ext_off,
  output logic tick,
  output logic ext_ph,
  output logic bus_clk
);
  logic div_q;
  logic tim_hi_q;

  assign tick = tim_half ? div_q : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= 1'b0;
      tim_hi_q <= 1'b0;
      ext_ph   <= 1'b0;
    end else begin
      div_q    <= tim_half ? ~div_q : 1'b0;
      tim_hi_q <= tick;
      if (!ext_half)
        ext_ph <= 1'b0;
      else if (tick)
        ext_ph <= ~ext_ph;
    end
  end

  // ext_ph = 0 means the next timing tick is a rising external edge
  always_comb begin
    if (ext_off)       bus_clk = 1'b0;
    else if (ext_half) bus_clk = ext_ph;
    else if (tim_half) bus_clk = tim_hi_q;
    else               bus_clk = clk;
  end
endmodule

// File: rtl/xbs_seq.sv
module xbs_seq
  import xbs_pkg::*;
#(
  parameter int LEAD_W   = 2,
  parameter int ACT_W    = 3,
  parameter int TRAIL_W  = 2,
  parameter int WAIT_MAX = 255,
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int BE_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              may_start,
  input  logic [LEAD_W-1:0]  cfg_lead,
  input  logic [ACT_W-1:0]   cfg_active,
  input  logic [TRAIL_W-1:0] cfg_trail,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cs_n,
  output logic              rnw,
  output logic              rd_n,
  output logic [BE_W-1:0]   wr_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              change
);
  localparam int CNT_W  = max3(LEAD_W, ACT_W, TRAIL_W);
  localparam int WAIT_W = $clog2(WAIT_MAX + 1);

  xbs_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic [WAIT_W-1:0] wcnt;
  logic              wr_q;
  logic [BE_W-1:0]   be_q;

  logic [CNT_W-1:0] lead_eff, act_eff, trail_ext;
  logic             start_ok, stretch, cnt_zero;

  assign lead_eff  = (cfg_lead == '0)   ? CNT_W'(1) : CNT_W'(cfg_lead);
  assign act_eff   = (cfg_active == '0) ? CNT_W'(1) : CNT_W'(cfg_active);
  assign trail_ext = CNT_W'(cfg_trail);
  assign cnt_zero  = (cnt == '0);
  assign start_ok  = tick && req_valid && !req_ready && may_start;
  assign stretch   = !bus_ready && (wcnt != WAIT_W'(WAIT_MAX));

  always_comb begin
    change = 1'b0;
    case (st)
      ST_IDLE:  change = start_ok;
      ST_LEAD:  change = tick && cnt_zero;
      ST_ACT:   change = tick && cnt_zero && !stretch;
      ST_TRAIL: change = tick && cnt_zero;
      default:  change = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      wcnt      <= '0;
      wr_q      <= 1'b0;
      be_q      <= '0;
      cs_n      <= 1'b1;
      rnw       <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= '1;
      addr      <= '0;
      wdata     <= '0;
      req_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_ok) begin
            cs_n  <= 1'b0;
            rnw   <= ~req_write;
            addr  <= req_addr;
            wdata <= req_wdata;
            wr_q  <= req_write;
            be_q  <= req_be;
            cnt   <= lead_eff - CNT_W'(1);
            st    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (cnt_zero) begin
              st   <= ST_ACT;
              cnt  <= act_eff - CNT_W'(1);
              wcnt <= '0;
              if (wr_q) wr_n <= ~be_q;
              else      rd_n <= 1'b0;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        ST_ACT: begin
          if (tick) begin
            if (!cnt_zero) begin
              cnt <= cnt - CNT_W'(1);
            end else if (stretch) begin
              wcnt <= wcnt + WAIT_W'(1);
            end else begin
              if (!wr_q) rsp_rdata <= bus_rdata;
              rd_n <= 1'b1;
              wr_n <= '1;
              if (trail_ext == '0) begin
                cs_n      <= 1'b1;
                rnw       <= 1'b1;
                req_ready <= 1'b1;
                st        <= ST_IDLE;
              end else begin
                cnt <= trail_ext - CNT_W'(1);
                st  <= ST_TRAIL;
              end
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            if (cnt_zero) begin
              cs_n      <= 1'b1;
              rnw       <= 1'b1;
              req_ready <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbs_tagger.sv
module xbs_tagger (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_half,
  input  logic change,
  input  logic ext_ph,
  output logic tag_valid,
  output logic tag_fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_valid <= 1'b0;
      tag_fall  <= 1'b0;
    end else begin
      tag_valid <= change && ext_half;
      if (change && ext_half) tag_fall <= ext_ph;
    end
  end
endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq #(
  parameter int LEAD_W   = 2,
  parameter int ACT_W    = 3,
  parameter int TRAIL_W  = 2,
  parameter int WAIT_MAX = 255,
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int BE_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tim_half,
  input  logic              cfg_ext_half,
  input  logic              cfg_ext_off,
  input  logic [LEAD_W-1:0]  cfg_lead,
  input  logic [ACT_W-1:0]   cfg_active,
  input  logic [TRAIL_W-1:0] cfg_trail,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_clk,
  output logic              bus_cs_n,
  output logic              bus_rnw,
  output logic              bus_rd_n,
  output logic [BE_W-1:0]   bus_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              edge_tag_valid,
  output logic              edge_tag_fall
);
  logic tick, ext_ph, change;

  xbs_clkgen u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .tim_half (cfg_tim_half),
    .ext_half (cfg_ext_half),
    .ext_off  (cfg_ext_off),
    .tick     (tick),
    .ext_ph   (ext_ph),
    .bus_clk  (bus_clk)
  );

  xbs_seq #(
    .LEAD_W(LEAD_W), .ACT_W(ACT_W), .TRAIL_W(TRAIL_W), .WAIT_MAX(WAIT_MAX),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .may_start  (~ext_ph),
    .cfg_lead   (cfg_lead),
    .cfg_active (cfg_active),
    .cfg_trail  (cfg_trail),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_write  (req_write),
    .req_be     (req_be),
    .bus_ready  (bus_ready),
    .bus_rdata  (bus_rdata),
    .req_ready  (req_ready),
    .rsp_rdata  (rsp_rdata),
    .cs_n       (bus_cs_n),
    .rnw        (bus_rnw),
    .rd_n       (bus_rd_n),
    .wr_n       (bus_wr_n),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .change     (change)
  );

  xbs_tagger u_tagger (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_half  (cfg_ext_half),
    .change    (change),
    .ext_ph    (ext_ph),
    .tag_valid (edge_tag_valid),
    .tag_fall  (edge_tag_fall)
  );
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
  parameter int ACT_W    = 3,
  parameter int WAIT_MAX = 255,
  parameter int BE_W     = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_ext_half,
  input logic            req_ready,
  input logic            bus_clk,
  input logic            bus_cs_n,
  input logic            bus_rnw,
  input logic            bus_rd_n,
  input logic [BE_W-1:0] bus_wr_n,
  input logic            edge_tag_valid,
  input logic            edge_tag_fall
);
  localparam int LIMIT = ((1 << ACT_W) - 1 + WAIT_MAX) * 2;

  logic        strobe_low;
  logic [15:0] low_run;
  assign strobe_low = !bus_rd_n || (bus_wr_n != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (strobe_low) low_run <= low_run + 16'd1;
    else                 low_run <= '0;
  end

  // R7: strobes only inside chip-select, never read and write together
  a_r7_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> !bus_cs_n);
  a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && (bus_wr_n != '1)));
  // R7: direction back to read while idle
  a_r7_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> bus_rnw);
  // R5: acknowledge is a single cycle and coincides with chip-select release
  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  a_r5_ack_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && !$past(bus_cs_n)));
  // R8: start aligned with a rising external edge
  a_r8_start_rising: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_cs_n) && cfg_ext_half) |-> (bus_clk && edge_tag_valid && !edge_tag_fall));
  // R6: strobe window bounded by the wait ceiling
  a_r6_wait_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(LIMIT));
endmodule

bind xbus_strobe_seq xbs_checker #(.ACT_W(ACT_W), .WAIT_MAX(WAIT_MAX), .BE_W(BE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_ext_half   (cfg_ext_half),
  .req_ready      (req_ready),
  .bus_clk        (bus_clk),
  .bus_cs_n       (bus_cs_n),
  .bus_rnw        (bus_rnw),
  .bus_rd_n       (bus_rd_n),
  .bus_wr_n       (bus_wr_n),
  .edge_tag_valid (edge_tag_valid),
  .edge_tag_fall  (edge_tag_fall)
);

// File: tb/xbus_strobe_seq_tb.sv
`timescale 1ns/100ps
module xbus_strobe_seq_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_tim_half = 0, cfg_ext_half = 0, cfg_ext_off = 0;
  logic [1:0]  cfg_lead = 2'd1;
  logic [2:0]  cfg_active = 3'd1;
  logic [1:0]  cfg_trail = 2'd0;
  logic        req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_rdata = '0;
  logic [1:0]  req_be = '0;
  logic        bus_ready = 0;
  logic        req_ready, bus_clk, bus_cs_n, bus_rnw, bus_rd_n;
  logic        edge_tag_valid, edge_tag_fall;
  logic [1:0]  bus_wr_n;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, rsp_rdata;

  int  total = 0, bad = 0;
  bit  finished = 0;

  xbus_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tim_half(cfg_tim_half), .cfg_ext_half(cfg_ext_half),
    .cfg_ext_off(cfg_ext_off), .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_be(req_be), .rsp_rdata(rsp_rdata), .bus_clk(bus_clk),
    .bus_cs_n(bus_cs_n), .bus_rnw(bus_rnw), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .edge_tag_valid(edge_tag_valid), .edge_tag_fall(edge_tag_fall)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    chk(bus_cs_n == 1'b1, "R1", "cs_n in reset", bus_cs_n, 1);
    chk(bus_rd_n == 1'b1 && bus_wr_n == 2'b11, "R1", "strobes in reset", {bus_rd_n, bus_wr_n}, 7);
    chk(bus_rnw == 1'b1 && req_ready == 1'b0, "R1", "rnw/ready in reset", {bus_rnw, req_ready}, 2);
  endtask

  task automatic run_access(input bit wr, input logic [1:0] be, input int ld, input int ac,
                            input int tr, input int wt, input bit th, input bit eh,
                            input logic [15:0] rdat, input logic [19:0] adr);
    int td, le, ae, we;
    int cs_f, st_f, st_r, cs_r, ack_n, acks;
    bit t0v, t0f, c0, rnw0, s_rd, sfv, sff, srv, srf, rnw_end;
    logic [1:0]  s_wr;
    logic [19:0] a0;
    logic [15:0] rd0, wd0;
    td = th ? 2 : 1;
    le = (ld == 0) ? 1 : ld;
    ae = (ac == 0) ? 1 : ac;
    we = (wt > 255) ? 255 : wt;
    cs_f = -1; st_f = -1; st_r = -1; cs_r = -1; ack_n = -1; acks = 0;
    t0v = 0; t0f = 0; c0 = 0; rnw0 = 0; s_rd = 1; sfv = 0; sff = 0; srv = 0; srf = 0;
    rnw_end = 0; s_wr = 2'b11; a0 = '0; rd0 = '0; wd0 = '0;
    @(negedge clk);
    cfg_tim_half = th; cfg_ext_half = eh; cfg_ext_off = 0;
    cfg_lead = 2'(ld); cfg_active = 3'(ac); cfg_trail = 2'(tr);
    req_write = wr; req_be = be; req_addr = adr; req_wdata = ~rdat; bus_rdata = rdat;
    bus_ready = 0; req_valid = 1;
    for (int n = 1; n < 4000; n++) begin
      bit slow;
      @(negedge clk);
      slow = !bus_rd_n || (bus_wr_n != 2'b11);
      if (cs_f < 0 && !bus_cs_n) begin
        cs_f = n; t0v = edge_tag_valid; t0f = edge_tag_fall; c0 = bus_clk; rnw0 = bus_rnw; a0 = bus_addr;
      end
      if (st_f < 0 && slow) begin
        st_f = n; s_rd = bus_rd_n; s_wr = bus_wr_n; sfv = edge_tag_valid; sff = edge_tag_fall; wd0 = bus_wdata;
      end else if (st_f >= 0 && st_r < 0 && !slow) begin
        st_r = n; srv = edge_tag_valid; srf = edge_tag_fall;
      end
      if (cs_f >= 0 && cs_r < 0 && bus_cs_n) begin
        cs_r = n; rnw_end = bus_rnw;
      end
      if (req_ready) begin
        acks++; ack_n = n; rd0 = rsp_rdata;
      end
      bus_ready = (st_f >= 0) && (n - st_f + 1 >= (ae + wt) * td);
      if (ack_n >= 0 && n == ack_n + 1) req_valid = 0;
      if (ack_n >= 0 && n >= ack_n + 3) break;
    end
    chk(st_f - cs_f == le * td, "R2", "lead sysclks", st_f - cs_f, le * td);
    chk(st_r - st_f == (ae + we) * td, (wt > 0) ? "R6" : "R3", "strobe low sysclks", st_r - st_f, (ae + we) * td);
    chk(cs_r - st_r == tr * td, "R4", "trail sysclks", cs_r - st_r, tr * td);
    chk(acks == 1 && ack_n == cs_r, "R5", "ack cycle", ack_n, cs_r);
    if (!wr) chk(rd0 == rdat, "R5", "read data", rd0, rdat);
    if (wr) begin
      chk(s_wr == ~be && s_rd == 1'b1, "R7", "write strobes", {s_rd, s_wr}, {1'b1, ~be});
      chk(rnw0 == 1'b0 && wd0 == ~rdat, "R7", "write dir/data", {rnw0, wd0}, {1'b0, ~rdat});
    end else begin
      chk(s_rd == 1'b0 && s_wr == 2'b11, "R7", "read strobes", {s_rd, s_wr}, 3);
      chk(rnw0 == 1'b1, "R7", "read dir", rnw0, 1);
    end
    chk(rnw_end == 1'b1 && a0 == adr, "R7", "rnw idle / addr", {rnw_end, a0}, {1'b1, adr});
    if (eh) begin
      chk(c0 == 1'b1 && t0v && !t0f, "R8", "start on rising edge", {c0, t0v, t0f}, 3'b110);
      chk(sfv && sff == (le % 2 == 1), "R9", "assert edge tag", {sfv, sff}, {1'b1, 1'(le % 2)});
      chk(srv && srf == ((le + ae + we) % 2 == 1), "R9", "release edge tag", {srv, srf},
          {1'b1, 1'((le + ae + we) % 2)});
    end else begin
      chk(!sfv && !srv && !t0v, "R9", "no tags in full mode", {t0v, sfv, srv}, 0);
    end
  endtask

  task automatic t_clock(input bit th, input bit eh, input bit off, input int exp_tr);
    int tr;
    logic prev;
    @(negedge clk);
    cfg_tim_half = th; cfg_ext_half = eh; cfg_ext_off = off;
    repeat (4) @(negedge clk);
    prev = bus_clk; tr = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (bus_clk != prev) tr++;
      prev = bus_clk;
    end
    chk(tr == exp_tr, "R10", "bus_clk transitions in 16 cycles", tr, exp_tr);
    if (off) chk(bus_clk == 1'b0, "R10", "held level", bus_clk, 0);
    cfg_ext_off = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_access(0, 2'b00, 1, 2, 1, 0, 0, 0, 16'hA55A, 20'h12345);
    run_access(0, 2'b00, 3, 0, 0, 0, 1, 0, 16'h1234, 20'h00F0F);
    run_access(1, 2'b01, 2, 3, 2, 0, 0, 1, 16'hBEEF, 20'hABCDE);
    run_access(1, 2'b11, 1, 7, 3, 2, 1, 1, 16'h0F0F, 20'h55555);
    run_access(0, 2'b00, 0, 1, 2, 3, 0, 1, 16'hC3C3, 20'h00001);
    run_access(1, 2'b10, 3, 2, 1, 1, 0, 1, 16'h7E7E, 20'h80000);
    run_access(0, 2'b00, 2, 1, 1, 300, 0, 1, 16'h9999, 20'h3C3C3);
    t_clock(0, 1, 0, 16);
    t_clock(1, 1, 0, 8);
    t_clock(1, 0, 0, 16);
    t_clock(0, 1, 1, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule